// File: doc/BRIEF.md
# Dual Trace Identifier Buffer with Self-Advancing Pointers

This block holds two small trace identifier stores side by side: one for section-level monitoring and one for path-level monitoring. A host bus reaches each store through its own data address. Each store has a single 5-bit pointer that serves both host reads and host writes. After every host access through a data address, that store's pointer moves on by one, so software can fill or dump a whole store with a run of accesses to the same address. The two pointers are packed into one shared pointer word at a third address. Software can read that word to find out where each pointer stands, or write it to move both pointers at once.

A second, independent read port serves an overhead inserter. The inserter picks a store and a word index and gets the word back one cycle later. This port never moves the host pointers. Host read data also appears one cycle after the access and holds until the next host read.

Top module: `trace_dual_buffer`

## Requirements
- R1: After reset both pointers are 0, and a read of the pointer word (host address 2) returns 0.
- R2: Host address 0 reaches the section store, address 1 the path store and address 2 the pointer word. A read of address 3 returns 0, and a write to address 3 changes no pointer and no stored word.
- R3: A host write to address 0 or 1 stores `host_wdata` at the current pointer of that store. That pointer then advances by one and the other pointer is unchanged.
- R4: A host read of address 0 or 1 returns the word at that store's current pointer on `host_rdata` one cycle later. That pointer then advances by one.
- R5: The pointer word carries the path pointer in bits 15:11 and the section pointer in bits 10:6. Bits 5:0 read as 0.
- R6: A host write to the pointer word loads both pointers from bits 15:11 (path) and 10:6 (section) in the same cycle. The write itself does not advance either pointer, and bits 5:0 of the written value are ignored.
- R7: A pointer at 31 wraps to 0 on the next access to its store.
- R8: When `ins_rd_en` is high, the inserter port returns word `ins_addr` on `ins_rdata` one cycle later, from the section store when `ins_buf_sel` is 0 and from the path store when it is 1. Inserter reads never change either pointer.
- R9: When a host write and an inserter read target the same word in the same cycle, the inserter receives the word as it was before the write. The new word is returned from the next cycle on.
- R10: The two stores are separate: a write to an index in one store leaves the word at the same index in the other store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0 section data, 1 path data, 2 pointer word, 3 unmapped |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid the cycle after a read |
| ins_rd_en | input | 1 | Inserter read strobe |
| ins_buf_sel | input | 1 | Inserter store choice: 0 section, 1 path |
| ins_addr | input | 5 | Inserter word index |
| ins_rdata | output | 16 | Inserter read data, valid the cycle after a read |

## Verification
Two functions can fall in the same cycle: a host write through a data address, and an inserter read of the very word that write targets. The bench first moves the section pointer with a pointer-word write. It then issues the host write and the matching inserter read in the same cycle. The scoreboard expects the old word on `ins_rdata`, and it expects the new word from a follow-up inserter read and from a host read after the pointer has come back round. A host read of one store alongside an inserter read of the other store is also driven, so that no path between the two ports can corrupt either result.

// File: rtl/trc_pkg.sv
package trc_pkg;
   typedef enum logic [1:0] {
      HA_SEC  = 2'd0,
      HA_PATH = 2'd1,
      HA_PTR  = 2'd2,
      HA_NONE = 2'd3
   } host_addr_e;

   localparam int BUF_SEC  = 0;
   localparam int BUF_PATH = 1;
   localparam int NUM_BUF  = 2;
endpackage

// File: rtl/trc_store.sv
module trc_store #(
   parameter int W     = 16,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          ra_en,
   input  logic [AW-1:0] ra_addr,
   output logic [W-1:0]  ra_q,
   input  logic          rb_en,
   input  logic [AW-1:0] rb_addr,
   output logic [W-1:0]  rb_q
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // Both read ports sample the array before this edge's write lands.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ra_q <= '0;
         rb_q <= '0;
      end else begin
         if (ra_en) ra_q <= mem[ra_addr];
         if (rb_en) rb_q <= mem[rb_addr];
      end
   end
endmodule

// File: rtl/trc_ptr_bank.sv
module trc_ptr_bank #(
   parameter int PTR_W = 5,
   parameter int NUM   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [NUM-1:0][PTR_W-1:0] load_val,
   input  logic [NUM-1:0]            inc,
   output logic [NUM-1:0][PTR_W-1:0] ptr
);
   localparam logic [PTR_W-1:0] STEP = PTR_W'(1);

   for (genvar g = 0; g < NUM; g++) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ptr[g] <= '0;
         else if (load)   ptr[g] <= load_val[g];
         else if (inc[g]) ptr[g] <= ptr[g] + STEP;
      end
   end
endmodule

// File: rtl/trc_host_dec.sv
module trc_host_dec
   import trc_pkg::*;
#(
   parameter int NUM = 2
) (
   input  logic           sel,
   input  logic           wr,
   input  logic [1:0]     addr,
   output logic [NUM-1:0] acc,
   output logic           ptr_wr,
   output logic           ptr_rd
);
   for (genvar g = 0; g < NUM; g++) begin : g_dec
      assign acc[g] = sel && (addr == 2'(g));
   end
   assign ptr_wr = sel &&  wr && (host_addr_e'(addr) == HA_PTR);
   assign ptr_rd = sel && !wr && (host_addr_e'(addr) == HA_PTR);
endmodule

// File: rtl/trace_dual_buffer.sv
module trace_dual_buffer
   import trc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 32,
   localparam int PTR_W    = $clog2(DEPTH),
   localparam int PATH_LSB = DATA_W - PTR_W,
   localparam int SEC_LSB  = DATA_W - 2 * PTR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              ins_rd_en,
   input  logic              ins_buf_sel,
   input  logic [PTR_W-1:0]  ins_addr,
   output logic [DATA_W-1:0] ins_rdata
);
   if (DATA_W < 2 * PTR_W) begin : g_bad_width
      $error("pointer word cannot hold two pointers");
   end
   if (DEPTH != (1 << PTR_W)) begin : g_bad_depth
      $error("DEPTH must be a power of two for pointer wrap");
   end

   logic [NUM_BUF-1:0]             acc;
   logic                           ptr_wr, ptr_rd;
   logic [NUM_BUF-1:0][PTR_W-1:0]  ptr, load_val;
   logic [NUM_BUF-1:0][DATA_W-1:0] hq, iq;
   logic [PTR_W-1:0]               ptr_sec, ptr_path;
   logic [DATA_W-1:0]              ptr_word, ptr_snap_q;
   host_addr_e                     rsel_q;
   logic                           ins_sel_q;

   trc_host_dec #(.NUM(NUM_BUF)) u_dec (
      .sel(host_sel), .wr(host_wr), .addr(host_addr),
      .acc(acc), .ptr_wr(ptr_wr), .ptr_rd(ptr_rd)
   );

   assign load_val[BUF_SEC]  = host_wdata[SEC_LSB  +: PTR_W];
   assign load_val[BUF_PATH] = host_wdata[PATH_LSB +: PTR_W];

   trc_ptr_bank #(.PTR_W(PTR_W), .NUM(NUM_BUF)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(ptr_wr),
      .load_val(load_val), .inc(acc), .ptr(ptr)
   );

   assign ptr_sec  = ptr[BUF_SEC];
   assign ptr_path = ptr[BUF_PATH];

   for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
      trc_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
         .clk(clk), .rst_n(rst_n),
         .we(acc[b] && host_wr), .waddr(ptr[b]), .wdata(host_wdata),
         .ra_en(acc[b] && !host_wr), .ra_addr(ptr[b]), .ra_q(hq[b]),
         .rb_en(ins_rd_en && (ins_buf_sel == 1'(b))), .rb_addr(ins_addr),
         .rb_q(iq[b])
      );
   end

   always_comb begin
      ptr_word = '0;
      ptr_word[PATH_LSB +: PTR_W] = ptr_path;
      ptr_word[SEC_LSB  +: PTR_W] = ptr_sec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsel_q     <= HA_NONE;
         ptr_snap_q <= '0;
         ins_sel_q  <= 1'b0;
      end else begin
         if (host_sel && !host_wr) rsel_q <= host_addr_e'(host_addr);
         if (ptr_rd)               ptr_snap_q <= ptr_word;
         if (ins_rd_en)            ins_sel_q <= ins_buf_sel;
      end
   end

   always_comb begin
      case (rsel_q)
         HA_SEC:  host_rdata = hq[BUF_SEC];
         HA_PATH: host_rdata = hq[BUF_PATH];
         HA_PTR:  host_rdata = ptr_snap_q;
         default: host_rdata = '0;
      endcase
   end

   assign ins_rdata = ins_sel_q ? iq[BUF_PATH] : iq[BUF_SEC];
endmodule

// File: rtl/trc_dual_buffer_chk.sv
module trc_dual_buffer_chk #(
   parameter int DATA_W = 16,
   parameter int PTR_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_sel,
   input logic              host_wr,
   input logic [1:0]        host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic [DATA_W-1:0] host_rdata,
   input logic              ins_rd_en,
   input logic [PTR_W-1:0]  ptr_sec,
   input logic [PTR_W-1:0]  ptr_path
);
   localparam int PATH_LSB = DATA_W - PTR_W;
   localparam int SEC_LSB  = DATA_W - 2 * PTR_W;
   localparam logic [PTR_W-1:0]  ONE  = PTR_W'(1);
   localparam logic [DATA_W-1:0] RSVD = (DATA_W'(1) << SEC_LSB) - DATA_W'(1);

   // R3, R4, R7: a section access advances only the section pointer, with wrap
   assert_sec_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      host_sel && host_addr == 2'd0 |=>
         ptr_sec == $past(ptr_sec) + ONE && $stable(ptr_path));

   // R4, R7: a path access advances only the path pointer
   assert_path_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      host_sel && host_addr == 2'd1 |=>
         ptr_path == $past(ptr_path) + ONE && $stable(ptr_sec));

   assert_ptr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      host_sel && host_wr && host_addr == 2'd2 |=>
         ptr_path == $past(host_wdata[PATH_LSB +: PTR_W]) &&
         ptr_sec  == $past(host_wdata[SEC_LSB  +: PTR_W]));

   // R8: with no host access, inserter traffic leaves pointers alone
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !host_sel |=> $stable(ptr_sec) && $stable(ptr_path));

   assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      host_sel && !host_wr && host_addr == 2'd2 |=> (host_rdata & RSVD) == '0);

   assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      host_sel && host_addr == 2'd3 |=>
         $stable(ptr_sec) && $stable(ptr_path) &&
         ($past(host_wr) || host_rdata == '0));
endmodule

bind trace_dual_buffer trc_dual_buffer_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
   .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
   .ins_rd_en(ins_rd_en), .ptr_sec(ptr_sec), .ptr_path(ptr_path)
);

// File: tb/test_trace_dual_buffer.sv
`timescale 1ns/1ps
module test_trace_dual_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0, host_wr = 1'b0;
   logic [1:0]  host_addr = 2'd0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        ins_rd_en = 1'b0, ins_buf_sel = 1'b0;
   logic [4:0]  ins_addr = '0;
   logic [15:0] ins_rdata;

   always #2 clk = ~clk;

   trace_dual_buffer i_trace_dual_buffer (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ins_rd_en(ins_rd_en), .ins_buf_sel(ins_buf_sel), .ins_addr(ins_addr),
      .ins_rdata(ins_rdata)
   );

   typedef struct { logic [15:0] exp; int req; } item_t;
   item_t hostq[$];
   item_t insq[$];
   int checks = 0, failures = 0;
   bit done = 0;

   // reference model
   logic [15:0] sm [32];
   logic [15:0] pm [32];
   logic [4:0]  ps = 0, pp = 0;

   // one cycle of stimulus, driven at a falling edge
   task automatic cyc(input logic hs, input logic hw, input logic [1:0] ha,
                      input logic [15:0] hd, input int hreq,
                      input logic ie, input logic ib, input logic [4:0] ia,
                      input int ireq);
      item_t it;
      host_sel = hs; host_wr = hw; host_addr = ha; host_wdata = hd;
      ins_rd_en = ie; ins_buf_sel = ib; ins_addr = ia;
      if (ie) begin
         it.exp = ib ? pm[ia] : sm[ia]; it.req = ireq;
         insq.push_back(it);
      end
      if (hs && !hw) begin
         case (ha)
            2'd0: it.exp = sm[ps];
            2'd1: it.exp = pm[pp];
            2'd2: it.exp = {pp, ps, 6'b0};
            default: it.exp = '0;
         endcase
         it.req = hreq;
         hostq.push_back(it);
      end
      if (hs) begin
         case (ha)
            2'd0: begin if (hw) sm[ps] = hd; ps = ps + 5'd1; end
            2'd1: begin if (hw) pm[pp] = hd; pp = pp + 5'd1; end
            2'd2: if (hw) begin pp = hd[15:11]; ps = hd[10:6]; end
            default: ;
         endcase
      end
      @(negedge clk);
      host_sel = 1'b0; ins_rd_en = 1'b0;
   endtask

   task automatic hwr(input logic [1:0] a, input logic [15:0] d, input int r);
      cyc(1'b1, 1'b1, a, d, r, 1'b0, 1'b0, 5'd0, 0);
   endtask
   task automatic hrd(input logic [1:0] a, input int r);
      cyc(1'b1, 1'b0, a, 16'h0, r, 1'b0, 1'b0, 5'd0, 0);
   endtask
   task automatic ird(input logic b, input logic [4:0] a, input int r);
      cyc(1'b0, 1'b0, 2'd0, 16'h0, 0, 1'b1, b, a, r);
   endtask

   // monitor: compare results one cycle after the issuing edge
   logic hv_d = 1'b0, iv_d = 1'b0;
   always @(posedge clk) begin
      hv_d <= host_sel && !host_wr;
      iv_d <= ins_rd_en;
   end
   always @(negedge clk) begin
      item_t it;
      if (hv_d && hostq.size() > 0) begin
         it = hostq.pop_front();
         checks++;
         if (host_rdata !== it.exp) begin
            failures++;
            $display("FAIL R%0d host_rdata actual=%h expected=%h", it.req, host_rdata, it.exp);
         end
      end
      if (iv_d && insq.size() > 0) begin
         it = insq.pop_front();
         checks++;
         if (ins_rdata !== it.exp) begin
            failures++;
            $display("FAIL R%0d ins_rdata actual=%h expected=%h", it.req, ins_rdata, it.exp);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      hrd(2'd2, 1);                                  // R1 reset pointers
      hrd(2'd3, 2);                                  // R2 unmapped reads 0
      for (int i = 0; i < 32; i++) hwr(2'd0, 16'hA000 + 16'(i), 3);   // R3
      for (int i = 0; i < 32; i++) hwr(2'd1, 16'h5000 + 16'(i * 3), 10); // R10
      hrd(2'd2, 7);                                  // R7 both wrapped to 0
      for (int i = 0; i < 4; i++) hrd(2'd0, 4);      // R4
      hrd(2'd1, 10);                                 // R10 path index 0 distinct
      hrd(2'd2, 5);                                  // R5 sec=4 path=1
      hwr(2'd2, {5'd30, 5'd31, 6'h3F}, 6);           // R6 load, reserved ignored
      hrd(2'd2, 6);                                  // R6 / R5 layout
      hrd(2'd0, 7);                                  // R7 word 31
      hrd(2'd0, 7);                                  // R7 wrapped to 0
      hrd(2'd1, 7); hrd(2'd1, 7); hrd(2'd1, 7);      // R7 path 30,31,0
      hwr(2'd3, 16'hFFFF, 2);                        // R2 write ignored
      hrd(2'd2, 2);
      hrd(2'd3, 2);
      ird(1'b0, 5'd7, 8); ird(1'b1, 5'd7, 8);        // R8
      ird(1'b0, 5'd31, 8); ird(1'b1, 5'd0, 8);
      hrd(2'd2, 8);                                  // R8 pointers unchanged
      // R8 host read of one store beside inserter read of the other
      cyc(1'b1, 1'b0, 2'd0, 16'h0, 4, 1'b1, 1'b1, 5'd9, 8);
      // R9 same-cycle host write and inserter read of one word
      hwr(2'd2, {5'd0, 5'd5, 6'd0}, 6);
      cyc(1'b1, 1'b1, 2'd0, 16'hBEEF, 9, 1'b1, 1'b0, 5'd5, 9);
      ird(1'b0, 5'd5, 9);                            // R9 new word visible
      ird(1'b1, 5'd5, 10);                           // R10 path untouched
      hwr(2'd2, {5'd0, 5'd5, 6'd0}, 6);
      hrd(2'd0, 9);                                  // R9 host sees new word
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      done = 1;
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule